// File: doc/BRIEF.md
# Gamma Correction Lookup Table

This block holds the color gamma table for one display output. Software loads the table by 32-bit writes to a single register. Each entry packs a red, a green and a blue value. Pixel logic then presents the three raw component codes of a pixel. Each code indexes the table on its own, and the block returns the corrected red, green and blue one cycle later.

A build-time parameter selects one of two configurations. The indexed configuration has 256 entries of 8-bit components. There, every write carries the entry number in its top byte. The streaming configuration has 1024 entries of 10-bit components. There, writes fill the table in order from an internal pointer. A write with the top bit set starts the fill again at entry 0.

A per-cycle enable decides whether correction is applied. When the enable is clear, the pixel codes pass through unchanged. Out of reset, the table holds an identity ramp.

Top module: `gamma_lut`

## Requirements
- R1: While reset is low and on the first cycle after it, `pix_valid_out`, all three component outputs and `overflow` are 0. After reset, every entry k holds the value k in each of its three fields.
- R2: With STREAM=0, a write with `wr_en` high stores entry `wr_data[31:24]`. The stored fields are red `wr_data[23:16]`, green `wr_data[15:8]` and blue `wr_data[7:0]`. In this configuration `overflow` stays 0.
- R3: With STREAM=1, the fields are red `wr_data[29:20]`, green `wr_data[19:10]` and blue `wr_data[9:0]`. Bit 30 is ignored. A write with bit 31 set stores entry 0 and moves the pointer to 1. A write with bit 31 clear stores the entry at the pointer and advances the pointer by one.
- R4: With STREAM=1, a write with bit 31 clear after entry 1023 has been written stores nothing and sets `overflow`. `overflow` then stays high until reset, even after a restart write.
- R5: With `gamma_en` high, each output takes its own field of the entry its own code selects. Red takes the red field of the entry `pix_r_in` selects, green the green field of the entry `pix_g_in` selects, and blue the blue field of the entry `pix_b_in` selects.
- R6: `pix_valid_out` equals `pix_valid_in` from one cycle earlier. The component outputs hold the result for the inputs of that same earlier cycle.
- R7: With `gamma_en` low, each output equals its input code from one cycle earlier.
- R8: A lookup in the same cycle as a write to the same entry returns the entry's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_data | input | 32 | Write word: entry fields plus index (STREAM=0) or restart bit (STREAM=1) |
| gamma_en | input | 1 | Apply correction when high, bypass when low |
| pix_valid_in | input | 1 | Pixel input valid |
| pix_r_in | input | CW | Red code (CW = 8, or 10 when STREAM=1) |
| pix_g_in | input | CW | Green code |
| pix_b_in | input | CW | Blue code |
| pix_valid_out | output | 1 | Pixel output valid, one cycle after input |
| pix_r_out | output | CW | Corrected red |
| pix_g_out | output | CW | Corrected green |
| pix_b_out | output | CW | Corrected blue |
| overflow | output | 1 | Sticky: streaming write past the last entry |

## Verification
The bench builds two instances side by side, one with STREAM=0 and one with STREAM=1. It checks both against the same clock and reset. The indexed instance takes random addresses, random data and random enables, so every one of its 256 entries can be reached. The streaming instance is filled through all 1024 entries, which brings the saturating pointer, the sticky overflow flag and the restart after overflow within reach. Directed steps cover the identity ramp at both ends of each table and a lookup of an entry in the same cycle it is written.

// File: rtl/gamma_lut.sv
module gamma_lut #(
  parameter bit STREAM = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [31:0]                   wr_data,
  input  logic                          gamma_en,
  input  logic                          pix_valid_in,
  input  logic [(STREAM ? 10 : 8)-1:0]  pix_r_in,
  input  logic [(STREAM ? 10 : 8)-1:0]  pix_g_in,
  input  logic [(STREAM ? 10 : 8)-1:0]  pix_b_in,
  output logic                          pix_valid_out,
  output logic [(STREAM ? 10 : 8)-1:0]  pix_r_out,
  output logic [(STREAM ? 10 : 8)-1:0]  pix_g_out,
  output logic [(STREAM ? 10 : 8)-1:0]  pix_b_out,
  output logic                          overflow
);
  localparam int CW    = STREAM ? 10 : 8;
  localparam int DEPTH = 1 << CW;
  localparam int EW    = 3 * CW;

  logic [EW-1:0] tbl [DEPTH];
  logic          we;
  logic [CW-1:0] wa;
  logic [EW-1:0] wd;

  generate
    if (STREAM) begin : g_stream
      localparam int PW = CW + 1;
      logic [PW-1:0] wr_ptr;
      logic          ovf_q;
      logic          unused_bit;
      logic          at_end;

      assign unused_bit = wr_data[30];
      assign at_end     = (wr_ptr == PW'(DEPTH));
      assign we         = wr_en & (wr_data[31] | ~at_end);
      assign wa         = wr_data[31] ? '0 : wr_ptr[CW-1:0];
      assign wd         = wr_data[EW-1:0];
      assign overflow   = ovf_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wr_ptr <= '0;
          ovf_q  <= 1'b0;
        end else if (wr_en) begin
          if (wr_data[31])  wr_ptr <= PW'(1);
          else if (at_end)  ovf_q  <= 1'b1;
          else              wr_ptr <= wr_ptr + PW'(1);
        end
      end

      assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[31] |=> wr_ptr == PW'(1));
      assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[31] && wr_ptr == PW'(DEPTH) |=> overflow && wr_ptr == PW'(DEPTH));
      assert_sticky_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    end else begin : g_index
      assign we       = wr_en;
      assign wa       = wr_data[31:24];
      assign wd       = wr_data[23:0];
      assign overflow = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) tbl[k] <= {3{k[CW-1:0]}};
    end else if (we) begin
      tbl[wa] <= wd;
    end
  end

  logic [EW-1:0] ent_r, ent_g, ent_b;
  assign ent_r = tbl[pix_r_in];
  assign ent_g = tbl[pix_g_in];
  assign ent_b = tbl[pix_b_in];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid_out <= 1'b0;
      pix_r_out     <= '0;
      pix_g_out     <= '0;
      pix_b_out     <= '0;
    end else begin
      pix_valid_out <= pix_valid_in;
      pix_r_out     <= gamma_en ? ent_r[EW-1 -: CW]   : pix_r_in;
      pix_g_out     <= gamma_en ? ent_g[2*CW-1 -: CW] : pix_g_in;
      pix_b_out     <= gamma_en ? ent_b[CW-1:0]       : pix_b_in;
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_in |=> pix_valid_out);
  assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_in |=> !pix_valid_out);
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gamma_en |=> pix_r_out == $past(pix_r_in) && pix_g_out == $past(pix_g_in)
                  && pix_b_out == $past(pix_b_in));

endmodule

// File: tb/test_gamma_lut.sv
module test_gamma_lut;
  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst_n;

  logic        iw_en, ien, ipv, ivo, iovf;
  logic [31:0] iw_data;
  logic [7:0]  ir, ig, ib, iro, igo, ibo;
  logic        sw_en, sen, spv, svo, sovf;
  logic [31:0] sw_data;
  logic [9:0]  sr, sg, sb, sro, sgo, sbo;

  gamma_lut #(.STREAM(1'b0)) i_gamma_lut (
    .clk(clk), .rst_n(rst_n), .wr_en(iw_en), .wr_data(iw_data), .gamma_en(ien),
    .pix_valid_in(ipv), .pix_r_in(ir), .pix_g_in(ig), .pix_b_in(ib),
    .pix_valid_out(ivo), .pix_r_out(iro), .pix_g_out(igo), .pix_b_out(ibo),
    .overflow(iovf));

  gamma_lut #(.STREAM(1'b1)) i_gamma_lut_stream (
    .clk(clk), .rst_n(rst_n), .wr_en(sw_en), .wr_data(sw_data), .gamma_en(sen),
    .pix_valid_in(spv), .pix_r_in(sr), .pix_g_in(sg), .pix_b_in(sb),
    .pix_valid_out(svo), .pix_r_out(sro), .pix_g_out(sgo), .pix_b_out(sbo),
    .overflow(sovf));

  logic [23:0] mi [256];
  logic [29:0] ms [1024];
  int sptr;
  bit ovf_m;
  int vecs = 0, errs = 0;

  function automatic logic [7:0] exp_i(bit en, logic [7:0] code, int fld);
    logic [23:0] e = mi[code];
    return en ? e[fld*8 +: 8] : code;
  endfunction

  function automatic logic [9:0] exp_s(bit en, logic [9:0] code, int fld);
    logic [29:0] e = ms[code];
    return en ? e[fld*10 +: 10] : code;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step_i(bit we, logic [31:0] d, bit en, bit pv,
                        logic [7:0] r, logic [7:0] g, logic [7:0] b, string req);
    logic [7:0] er, eg, eb;
    iw_en = we; iw_data = d; ien = en; ipv = pv; ir = r; ig = g; ib = b;
    er = exp_i(en, r, 2); eg = exp_i(en, g, 1); eb = exp_i(en, b, 0);
    @(posedge clk);
    if (we) mi[d[31:24]] = d[23:0];
    @(negedge clk);
    iw_en = 1'b0; ipv = 1'b0;
    chk({req, " valid (R6)"}, 32'(ivo), 32'(pv));
    if (pv) chk(req, {8'h0, iro, igo, ibo}, {8'h0, er, eg, eb});
    chk("R2 overflow low", 32'(iovf), 32'd0);
  endtask

  task automatic step_s(bit we, logic [31:0] d, bit en, bit pv,
                        logic [9:0] r, logic [9:0] g, logic [9:0] b, string req);
    logic [9:0] er, eg, eb;
    sw_en = we; sw_data = d; sen = en; spv = pv; sr = r; sg = g; sb = b;
    er = exp_s(en, r, 2); eg = exp_s(en, g, 1); eb = exp_s(en, b, 0);
    @(posedge clk);
    if (we) begin
      if (d[31]) begin ms[0] = d[29:0]; sptr = 1; end
      else if (sptr < 1024) begin ms[sptr] = d[29:0]; sptr++; end
      else ovf_m = 1'b1;
    end
    @(negedge clk);
    sw_en = 1'b0; spv = 1'b0;
    chk({req, " valid (R6)"}, 32'(svo), 32'(pv));
    if (pv) chk(req, {2'b0, sro, sgo, sbo}, {2'b0, er, eg, eb});
    chk("R4 overflow", 32'(sovf), 32'(ovf_m));
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    iw_en = 0; iw_data = 0; ien = 0; ipv = 0; ir = 0; ig = 0; ib = 0;
    sw_en = 0; sw_data = 0; sen = 0; spv = 0; sr = 0; sg = 0; sb = 0;
    for (int k = 0; k < 256; k++) mi[k] = {3{k[7:0]}};
    for (int k = 0; k < 1024; k++) ms[k] = {3{k[9:0]}};
    sptr = 0; ovf_m = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset idx", {iovf, ivo, iro, igo, ibo}, 32'd0);
    chk("R1 reset stream", {sovf, svo, sro, sgo, sbo}, 32'd0);
    rst_n = 1'b1;

    step_i(0, 0, 1, 1, 8'd0, 8'd128, 8'd255, "R1 identity idx");
    step_s(0, 0, 1, 1, 10'd0, 10'd512, 10'd1023, "R1 identity stream");

    for (int n = 0; n < 400; n++)
      step_i(1'($urandom % 2), $urandom, ($urandom % 4) != 0, ($urandom % 4) != 0,
             8'($urandom), 8'($urandom), 8'($urandom), "R2/R5 random idx");
    step_i(0, 0, 0, 1, 8'd3, 8'd200, 8'd91, "R7 bypass idx");
    step_i(1, {8'd77, 24'h123456}, 1, 1, 8'd77, 8'd77, 8'd77, "R8 same-cycle idx");
    step_i(0, 0, 1, 1, 8'd77, 8'd77, 8'd77, "R2 new value idx");

    step_s(1, {2'b10, 30'h2AB_CDEF1}, 1, 1, 10'd0, 10'd0, 10'd0, "R8 restart same-cycle");
    step_s(0, 0, 1, 1, 10'd0, 10'd0, 10'd0, "R3 entry0 stream");
    for (int k = 1; k < 1024; k++)
      step_s(1, {2'b01, 30'($urandom)}, ($urandom % 4) != 0, ($urandom % 2) != 0,
             10'($urandom), 10'($urandom), 10'($urandom), "R3/R5 fill stream");
    step_s(0, 0, 1, 1, 10'd1023, 10'd1, 10'd1022, "R3 last entries");
    for (int k = 0; k < 3; k++)
      step_s(1, {2'b00, 30'h3FFF_FFFF}, 1, 1, 10'd1023, 10'd1023, 10'd1023, "R4 past end");
    step_s(1, {2'b10, 30'h155_5555}, 1, 1, 10'd5, 10'd6, 10'd7, "R4 restart after overflow");
    step_s(1, {2'b00, 30'h0AA_AAAA}, 1, 1, 10'd0, 10'd1, 10'd2, "R3 resume at 1");
    step_s(0, 0, 0, 1, 10'd1000, 10'd17, 10'd640, "R7 bypass stream");
    for (int n = 0; n < 300; n++)
      step_s(($urandom % 3) == 0, {1'($urandom % 8 == 0), 31'($urandom)},
             ($urandom % 4) != 0, ($urandom % 4) != 0,
             10'($urandom), 10'($urandom), 10'($urandom), "R5 random stream");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule